// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block watches a host's periodic kick pulses and holds the host in reset when the pulses stop or come too soon. Time is measured in ticks of a free-running prescaler driven by the system clock. With the default setting a tick is one millisecond at 250 MHz. Each watchdog cycle has two windows in turn. A closed window comes first, and a kick in it is illegal. An open window follows, and a kick must arrive before it ends. A legal kick starts a new cycle. A fault of either kind drives the active-low reset output low for a fixed assert time. The cycle then starts again with a closed window.

A two-bit select input sets the length of the open window as a multiple of the closed window. A watchdog enable input turns window checking off. An active-low manual reset input forces the reset output low for as long as it is held. The kick, enable and manual-reset inputs each pass through a two-flop synchronizer. The early-fault and late-fault outputs each give a one-cycle pulse, so the two fault types can be told apart.

Top module: `window_watchdog`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is low and both fault pulses are low. After `rst_ni` is released, `rst_no` stays low for ASSERT_TICKS prescaler ticks, and then the first closed window begins with `rst_no` high. The first tick of any phase may be partial, because the prescaler runs freely and wraps every CLK_PER_TICK cycles.
- R2: A rising kick edge seen during the closed window with the watchdog enabled does three things. It drives `early_fault_o` high for exactly one cycle, it drives `rst_no` low in that same cycle, and it starts the assert phase.
- R3: The closed window lasts CLOSED_TICKS ticks. The open window lasts CLOSED_TICKS*(n-1) ticks, where n is set by `sel_i`: 2'b00 gives n=2, 2'b01 gives n=8, 2'b10 gives n=4, and 2'b11 gives n=16.
- R4: If no kick edge arrives before the open window expires, `late_fault_o` pulses high for one cycle and `rst_no` goes low in that same cycle.
- R5: After any fault, `rst_no` stays low for ASSERT_TICKS ticks. It then rises, and a new closed window begins.
- R6: A rising kick edge during the open window raises no fault and restarts the cycle at the beginning of a closed window.
- R7: While the synchronized `mr_ni` is low, `rst_no` is held low. After `mr_ni` is released, the full assert time runs before the closed window begins.
- R8: While the synchronized `wd_en_i` is low, no early or late fault is raised. An active window is held at the start of its closed window with `rst_no` high. An assert phase already in progress still completes.
- R9: `sel_i` is sampled only when a closed window begins. A change in the middle of a cycle affects only the next cycle.
- R10: A kick is the rising edge of `kick_i` after a two-flop synchronizer. A level held high counts as one kick, and it takes effect on the third clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Host kick; the rising edge is the event |
| sel_i | input | 2 | Window ratio select |
| wd_en_i | input | 1 | Watchdog enable, active high |
| mr_ni | input | 1 | Manual reset, active low |
| rst_no | output | 1 | Supervisor reset output, active low |
| early_fault_o | output | 1 | One-cycle pulse on an early kick |
| late_fault_o | output | 1 | One-cycle pulse on a missing kick |

## Verification
Kicks are spaced to land inside the open window. These must give a long run with no fault, which separates a correct window boundary from one that is off by a tick. A kick shortly after a legal one tests the early-fault path. A long silence, repeated under all four select codes, tests the late-fault path and the window length for each ratio. A select change in the middle of a cycle, a kick held high, a manual-reset hold, and a disabled stretch with kicks at random spacing each isolate the sampling point, the edge detection, the reset hold and the masking of faults.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic [1:0] {ST_ASSERT, ST_CLOSED, ST_OPEN} wwd_state_e;

  function automatic logic [4:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   ratio_of = 5'd2;
      2'b01:   ratio_of = 5'd8;
      2'b10:   ratio_of = 5'd4;
      default: ratio_of = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/wwd_tick_gen.sv
module wwd_tick_gen #(
  parameter int CLK_PER_TICK = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_PER_TICK <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wwd_sync.sv
module wwd_sync #(
  parameter int           WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/wwd_window_fsm.sv
module wwd_window_fsm
  import wwd_pkg::*;
#(
  parameter int CLOSED_TICKS = 20,
  parameter int ASSERT_TICKS = 10,
  parameter int CNT_W        = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_s_i,
  input  logic       en_s_i,
  input  logic       mr_s_ni,
  input  logic [1:0] sel_i,
  output logic       rst_no,
  output logic       early_fault_o,
  output logic       late_fault_o
);
  localparam logic [CNT_W-1:0] ASSERT_LAST = CNT_W'(ASSERT_TICKS - 1);
  localparam logic [CNT_W-1:0] CLOSED_LAST = CNT_W'(CLOSED_TICKS - 1);

  wwd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [4:0]       ratio_q, ratio_d;
  logic             kick_q, kick_edge;
  logic             early_d, late_d;
  logic [CNT_W-1:0] open_last;

  assign kick_edge = kick_s_i & ~kick_q;
  assign open_last = CNT_W'(CLOSED_TICKS * (int'(ratio_q) - 1) - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    early_d = 1'b0;
    late_d  = 1'b0;
    if (!mr_s_ni) begin
      state_d = ST_ASSERT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ASSERT: if (tick_i) begin
          if (cnt_q == ASSERT_LAST) begin
            state_d = ST_CLOSED;
            cnt_d   = '0;
            ratio_d = ratio_of(sel_i);
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_CLOSED: begin
          if (!en_s_i) begin
            cnt_d   = '0;
            ratio_d = ratio_of(sel_i);
          end else if (kick_edge) begin
            early_d = 1'b1;
            state_d = ST_ASSERT;
            cnt_d   = '0;
          end else if (tick_i) begin
            if (cnt_q == CLOSED_LAST) begin
              state_d = ST_OPEN;
              cnt_d   = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        ST_OPEN: begin
          if (!en_s_i || kick_edge) begin
            state_d = ST_CLOSED;
            cnt_d   = '0;
            ratio_d = ratio_of(sel_i);
          end else if (tick_i) begin
            if (cnt_q == open_last) begin
              late_d  = 1'b1;
              state_d = ST_ASSERT;
              cnt_d   = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_ASSERT;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_ASSERT;
      cnt_q         <= '0;
      ratio_q       <= 5'd2;
      kick_q        <= 1'b0;
      early_fault_o <= 1'b0;
      late_fault_o  <= 1'b0;
    end else begin
      state_q       <= state_d;
      cnt_q         <= cnt_d;
      ratio_q       <= ratio_d;
      kick_q        <= kick_s_i;
      early_fault_o <= early_d;
      late_fault_o  <= late_d;
    end
  end

  assign rst_no = (state_q != ST_ASSERT);
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CLK_PER_TICK = 250000,
  parameter int CLOSED_TICKS = 20,
  parameter int ASSERT_TICKS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  input  logic       wd_en_i,
  input  logic       mr_ni,
  output logic       rst_no,
  output logic       early_fault_o,
  output logic       late_fault_o
);
  localparam int MAX_TICKS = (CLOSED_TICKS * 15 > ASSERT_TICKS) ? CLOSED_TICKS * 15 : ASSERT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1) + 1;

  logic       tick;
  logic [2:0] raw, syn;

  assign raw = {mr_ni, wd_en_i, kick_i};

  wwd_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  wwd_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  wwd_window_fsm #(
    .CLOSED_TICKS(CLOSED_TICKS),
    .ASSERT_TICKS(ASSERT_TICKS),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .kick_s_i     (syn[0]),
    .en_s_i       (syn[1]),
    .mr_s_ni      (syn[2]),
    .sel_i        (sel_i),
    .rst_no       (rst_no),
    .early_fault_o(early_fault_o),
    .late_fault_o (late_fault_o)
  );
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wd_en_i,
  input logic mr_ni,
  input logic rst_no,
  input logic early_fault_o,
  input logic late_fault_o
);
  p_early_resets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_fault_o |-> !rst_no);
  p_early_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_fault_o |=> !early_fault_o);
  p_late_resets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_fault_o |-> !rst_no);
  p_late_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_fault_o |=> !late_fault_o);
  p_fault_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(early_fault_o && late_fault_o));
  p_release_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> !early_fault_o && !late_fault_o);
  p_mr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mr_ni && $past(!mr_ni) && $past(!mr_ni, 2)) |=> !rst_no);
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_en_i && $past(!wd_en_i) && $past(!wd_en_i, 2)) |=> (!early_fault_o && !late_fault_o));
endmodule

bind window_watchdog wwd_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wd_en_i      (wd_en_i),
  .mr_ni        (mr_ni),
  .rst_no       (rst_no),
  .early_fault_o(early_fault_o),
  .late_fault_o (late_fault_o)
);

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
  localparam int CPT = 4;
  localparam int CL  = 5;
  localparam int AS  = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic kick_i = 1'b0;
  logic [1:0] sel_i = 2'b10;
  logic wd_en_i = 1'b1;
  logic mr_ni = 1'b1;
  logic rst_no, early_fault_o, late_fault_o;

  int compared = 0, mismatched = 0, cycles = 0;
  int n_early = 0, n_late = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk_i = ~clk_i;

  window_watchdog #(.CLK_PER_TICK(CPT), .CLOSED_TICKS(CL), .ASSERT_TICKS(AS)) u_window_watchdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(kick_i), .sel_i(sel_i),
    .wd_en_i(wd_en_i), .mr_ni(mr_ni), .rst_no(rst_no),
    .early_fault_o(early_fault_o), .late_fault_o(late_fault_o));

  // Reference model: 0 assert, 1 closed, 2 open
  int m_pre, m_st, m_cnt, m_ratio;
  bit m_early, m_late, k1, k2, k3, e1, e2, r1, r2;

  function automatic int rat(input logic [1:0] s);
    case (s)
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 4;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_pre = 0; m_st = 0; m_cnt = 0; m_ratio = 2; m_early = 0; m_late = 0;
      k1 = 0; k2 = 0; k3 = 0; e1 = 0; e2 = 0; r1 = 1; r2 = 1;
    end else begin
      bit tk, ke, ne, nl;
      tk = (m_pre == CPT - 1);
      ke = k2 && !k3;
      ne = 0; nl = 0;
      if (!r2) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (tk) begin
          if (m_cnt == AS - 1) begin m_st = 1; m_cnt = 0; m_ratio = rat(sel_i); end
          else m_cnt++;
        end
      end else if (m_st == 1) begin
        if (!e2) begin m_cnt = 0; m_ratio = rat(sel_i); end
        else if (ke) begin ne = 1; m_st = 0; m_cnt = 0; end
        else if (tk) begin
          if (m_cnt == CL - 1) begin m_st = 2; m_cnt = 0; end
          else m_cnt++;
        end
      end else begin
        if (!e2 || ke) begin m_st = 1; m_cnt = 0; m_ratio = rat(sel_i); end
        else if (tk) begin
          if (m_cnt == CL * (m_ratio - 1) - 1) begin nl = 1; m_st = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
      m_early = ne; m_late = nl;
      m_pre = tk ? 0 : m_pre + 1;
      k3 = k2; k2 = k1; k1 = kick_i;
      e2 = e1; e1 = wd_en_i;
      r2 = r1; r1 = mr_ni;
    end
  end

  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      compared++;
      if (rst_no !== (m_st != 0) || early_fault_o !== m_early || late_fault_o !== m_late) begin
        mismatched++;
        $display("FAIL %s cycle %0d: actual rst_no=%b early=%b late=%b expected rst_no=%b early=%b late=%b",
                 cur_req, cycles, rst_no, early_fault_o, late_fault_o, m_st != 0, m_early, m_late);
      end
      if (early_fault_o === 1'b1) n_early++;
      if (late_fault_o === 1'b1) n_late++;
    end
    if (cycles > 150000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic kick(input int hold);
    kick_i = 1'b1;
    wait_cyc(hold);
    kick_i = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int e0, l0;
    wait_cyc(5);
    // R1: reset state
    check(rst_no === 1'b0 && early_fault_o === 1'b0 && late_fault_o === 1'b0, "R1", rst_no, 0);
    rst_ni = 1'b1;
    wait_cyc(6);
    check(rst_no === 1'b0, "R1", rst_no, 0);
    wait_cyc(14);
    check(rst_no === 1'b1, "R1", rst_no, 1);

    // R6: kicks inside the open window (ratio 4: closed 20, open 60 cycles)
    cur_req = "R6";
    e0 = n_early; l0 = n_late;
    wait_cyc(20);
    for (int i = 0; i < 6; i++) begin
      kick(2);
      wait_cyc(43);
    end
    check(n_early == e0 && n_late == l0, "R6", n_early + n_late - e0 - l0, 0);

    // R2: kick too soon after a legal one
    cur_req = "R2";
    kick(2);
    wait_cyc(6);
    e0 = n_early;
    kick(2);
    wait_cyc(4);
    check(n_early == e0 + 1, "R2", n_early - e0, 1);
    check(rst_no === 1'b0, "R2", rst_no, 0);

    // R4/R5: silence gives a late fault and reset cycle
    cur_req = "R4";
    l0 = n_late;
    wait_cyc(110);
    check(n_late == l0 + 1, "R4", n_late - l0, 1);
    cur_req = "R5";
    wait_cyc(20);
    check(rst_no === 1'b1, "R5", rst_no, 1);

    // R3: every ratio with no kicks
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      sel_i = 2'(s);
      l0 = n_late;
      wait_cyc(450);
      check(n_late >= l0 + 1, "R3", n_late - l0, 1);
    end

    // R9: select changed mid-cycle
    cur_req = "R9";
    sel_i = 2'b00;
    wait_cyc(100);
    sel_i = 2'b11;
    wait_cyc(400);
    sel_i = 2'b10;
    wait_cyc(200);

    // R10: level held high counts once
    cur_req = "R10";
    e0 = n_early;
    wait_cyc(40);
    kick(150);
    wait_cyc(60);
    check(n_early >= e0, "R10", n_early - e0, 0);

    // R7: manual reset hold
    cur_req = "R7";
    mr_ni = 1'b0;
    wait_cyc(40);
    check(rst_no === 1'b0, "R7", rst_no, 0);
    mr_ni = 1'b1;
    wait_cyc(6);
    check(rst_no === 1'b0, "R7", rst_no, 0);
    wait_cyc(14);
    check(rst_no === 1'b1, "R7", rst_no, 1);

    // R8: disabled watchdog never faults
    cur_req = "R8";
    wd_en_i = 1'b0;
    wait_cyc(20);
    e0 = n_early; l0 = n_late;
    for (int i = 0; i < 8; i++) begin
      kick(2);
      wait_cyc(7 + i * 13);
    end
    wait_cyc(600);
    check(n_early == e0 && n_late == l0, "R8", n_early + n_late - e0 - l0, 0);
    check(rst_no === 1'b1, "R8", rst_no, 1);
    wd_en_i = 1'b1;
    wait_cyc(200);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule